// File: doc/BRIEF.md
# Halfword Prefetch Queue

This block keeps a small queue of upcoming instruction halfwords read ahead from cartridge ROM while the processor has nothing else for the bus to do. The processor gives it an idle clock on `step_i`. Each idle clock counts down the wait state of the fetch in progress. When the count runs out, the block fetches the halfword at its load address, stores it, and moves the load address on by two bytes. The wait state for a sequential halfword access arrives on `seq_wait_i` and is captured when a fetch finishes, so the next fetch waits for that many idle clocks. The block does not compute wait states.

The processor points the queue at an address with `sync_i`. It takes data out with `pop_i`, either one halfword or, with `pop_word_i` set, a 32-bit word built from two halfwords. If the sync address is the current head, the queue keeps its contents. Any other address discards the contents and loading restarts there. A cartridge access that does not go through the queue asserts `flush_i`. This empties the queue and stops loading until the next sync.

The controller has three states. **IDLE** means empty and not loading. **FILL** means loading with free slots. **FULL** means all slots are occupied and loading is paused. The transitions are:
- *start*: IDLE to FILL on a sync.
- *fill_up*: FILL to FULL when the last free slot is written.
- *drain*: FULL to FILL when a pop frees a slot.
- *retarget*: FULL to FILL on a sync to a non-head address. FILL also stays in FILL through a restart.
- *flush*: any state to IDLE on `flush_i`.

Top module: `pfq_top`

## Requirements
- R1: After reset the queue is IDLE and `level_o` is 0. `rom_req_o` stays low, even with `step_i` high.
- R2: A sync to an address that is not the current head, or any sync while IDLE, does the following:
  - It empties the queue.
  - It sets the head and load address to `sync_addr_i` with bit 0 cleared.
  - It loads the wait counter with `seq_wait_i`.
  - Loading restarts from that address.
- R3: A sync to the current head address while FILL or FULL leaves the contents, the level and the load progress unchanged.
- R4: While FILL, each cycle with `step_i` decrements the wait counter. On the step where the counter is 1, `rom_req_o` is high in that same cycle and the counter reloads from `seq_wait_i`. A `seq_wait_i` of 0 is treated as 1. Cycles without `step_i` make no progress.
- R5: A fetch reads the 16-bit word at `rom_addr_o` (the load address) and stores it in slot (address >> 1) mod DEPTH. The load address then advances by 2. Halfwords leave the queue in fetch order.
- R6: While the queue holds DEPTH halfwords, no fetch is issued and `step_i` is ignored, with the wait counter frozen.
- R7: A halfword pop (`pop_word_i`=0) with level at least 1 removes the oldest halfword, which `rd_data_o[15:0]` shows before the pop. The level then drops by 1.
- R8: A word pop (`pop_word_i`=1) with level at least 2 removes two halfwords. The oldest is shown on `rd_data_o[15:0]` and the next on `rd_data_o[31:16]`. A word pop with level below 2, or a halfword pop at level 0, is ignored.
- R9: `flush_i` empties the queue and returns it to IDLE. No fetch occurs until the next sync.
- R10: In a cycle with `flush_i` or `sync_i`, step and pop requests are ignored. `flush_i` takes precedence over `sync_i`.
- R11: A pop and a fetch in the same cycle both take effect, and the level changes by their net amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | One idle bus clock available this cycle |
| seq_wait_i | input | WAIT_W | Wait count for the next sequential halfword fetch |
| sync_i | input | 1 | Point the queue at `sync_addr_i` |
| sync_addr_i | input | ADDR_W | Byte address for the sync |
| flush_i | input | 1 | Non-prefetched cartridge access; empties the queue |
| pop_i | input | 1 | Remove data from the head |
| pop_word_i | input | 1 | Pop size: 1 means two halfwords, 0 means one |
| rom_req_o | output | 1 | Halfword fetch this cycle |
| rom_addr_o | output | ADDR_W | Fetch byte address (the load address) |
| rom_data_i | input | 16 | ROM halfword at `rom_addr_o`, in the same cycle |
| rd_data_o | output | 32 | Head halfword in the low half, the next halfword in the high half |
| level_o | output | CNT_W | Number of halfwords held |

## Verification
Directed patterns are run first, each aimed at one behaviour:
- Fills at wait values of 1, 2 and 3 separate the per-step countdown from a fixed delay.
- Runs with gaps in `step_i` show that progress needs idle clocks.
- Filling to capacity and then stepping confirms that loading stops.
- Pops of both sizes at level 1, level 2 and level 0 separate accepted pops from ignored ones and check the halfword order within a word.
- Syncs to the head and to other addresses distinguish keeping the contents from restarting.
- Flush-and-sync collisions fix the precedence between them.

A long pseudo-random mix of steps, wait values, pops, syncs and flushes then runs against a behavioural queue model, with the outputs compared on every clock.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        PF_IDLE = 2'd0,
        PF_FILL = 2'd1,
        PF_FULL = 2'd2
    } pf_state_e;
endpackage

// File: rtl/pfq_slots.sv
module pfq_slots #(
    parameter int DEPTH = 8,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_lo,
    output logic [15:0]      rd_hi
);
    localparam logic [IDX_W-1:0] IDX_ONE = 1;

    logic [15:0] slot_q [DEPTH];
    logic [IDX_W-1:0] rd_idx_hi;

    assign rd_idx_hi = rd_idx + IDX_ONE;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_lo = slot_q[rd_idx];
    assign rd_hi = slot_q[rd_idx_hi];
endmodule

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 25,
    parameter int WAIT_W = 4,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [WAIT_W-1:0] seq_wait_i,
    input  logic              sync_i,
    input  logic [ADDR_W-1:0] sync_addr_i,
    input  logic              flush_i,
    input  logic              pop_i,
    input  logic              pop_word_i,
    output logic              fetch_o,
    output logic [ADDR_W-1:0] load_addr_o,
    output logic [ADDR_W-1:0] head_addr_o,
    output logic [CNT_W-1:0]  level_o
);
    localparam logic [CNT_W-1:0]  FULL_LVL = CNT_W'(DEPTH);
    localparam logic [WAIT_W-1:0] WAIT_ONE = 1;

    pf_state_e         state_q, state_d;
    logic [WAIT_W-1:0] wait_q;
    logic [ADDR_W-1:0] load_q, head_q, sync_al;
    logic [CNT_W-1:0]  level_q, level_d, pop_need;
    logic [WAIT_W-1:0] wait_load;
    logic              ctl_cycle, sync_hit, stepping, pop_ok;

    // Output/next-value logic
    always_comb begin
        sync_al   = {sync_addr_i[ADDR_W-1:1], 1'b0};
        sync_hit  = (state_q != PF_IDLE) && (sync_al == head_q);
        ctl_cycle = flush_i || sync_i;
        stepping  = !ctl_cycle && (state_q == PF_FILL) && step_i;
        fetch_o   = stepping && (wait_q <= WAIT_ONE);
        wait_load = (seq_wait_i == '0) ? WAIT_ONE : seq_wait_i;
        pop_need  = pop_word_i ? CNT_W'(2) : CNT_W'(1);
        pop_ok    = !ctl_cycle && pop_i && (level_q >= pop_need);
        level_d   = level_q + CNT_W'(fetch_o) - (pop_ok ? pop_need : '0);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_IDLE: if (!flush_i && sync_i) state_d = PF_FILL;               // start
            PF_FILL: begin
                if (flush_i)                            state_d = PF_IDLE;    // flush
                else if (!sync_i && level_d == FULL_LVL) state_d = PF_FULL;   // fill_up
            end
            PF_FULL: begin
                if (flush_i)                            state_d = PF_IDLE;    // flush
                else if (sync_i && !sync_hit)           state_d = PF_FILL;    // retarget
                else if (!sync_i && level_d < FULL_LVL) state_d = PF_FILL;    // drain
            end
            default: state_d = PF_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PF_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q  <= '0;
            load_q  <= '0;
            head_q  <= '0;
            level_q <= '0;
        end else if (flush_i) begin
            level_q <= '0;
        end else if (sync_i) begin
            if (!sync_hit) begin
                level_q <= '0;
                head_q  <= sync_al;
                load_q  <= sync_al;
                wait_q  <= wait_load;
            end
        end else begin
            if (stepping) wait_q <= fetch_o ? wait_load : wait_q - WAIT_ONE;
            if (fetch_o)  load_q <= load_q + ADDR_W'(2);
            if (pop_ok)   head_q <= head_q + (ADDR_W'(pop_need) << 1);
            level_q <= level_d;
        end
    end

    assign load_addr_o = load_q;
    assign head_addr_o = head_q;
    assign level_o     = level_q;

    // Assertions
    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL_LVL);
    a_r6_no_fetch_full: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> level_q < FULL_LVL);
    a_r5_load_advance: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> load_q == $past(load_q) + ADDR_W'(2));
    a_r4_wait_reload: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> wait_q == $past(wait_load));
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (level_q == '0) && (state_q == PF_IDLE));
    a_r3_sync_hit_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_i && !flush_i && sync_hit) |=> $stable(level_q) && $stable(load_q));
    a_r8_word_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && pop_word_i && !fetch_o) |=> level_q == $past(level_q) - CNT_W'(2));
endmodule

// File: rtl/pfq_top.sv
module pfq_top #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 25,
    parameter int WAIT_W = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [WAIT_W-1:0] seq_wait_i,
    input  logic              sync_i,
    input  logic [ADDR_W-1:0] sync_addr_i,
    input  logic              flush_i,
    input  logic              pop_i,
    input  logic              pop_word_i,
    output logic              rom_req_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [15:0]       rom_data_i,
    output logic [31:0]       rd_data_o,
    output logic [CNT_W-1:0]  level_o
);
    logic              fetch;
    logic [ADDR_W-1:0] load_addr, head_addr;
    logic [15:0]       rd_lo, rd_hi;

    pfq_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .seq_wait_i(seq_wait_i),
        .sync_i(sync_i), .sync_addr_i(sync_addr_i), .flush_i(flush_i),
        .pop_i(pop_i), .pop_word_i(pop_word_i), .fetch_o(fetch),
        .load_addr_o(load_addr), .head_addr_o(head_addr), .level_o(level_o)
    );

    pfq_slots #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_slots (
        .clk(clk), .rst_n(rst_n), .wr_en(fetch), .wr_idx(load_addr[IDX_W:1]),
        .wr_data(rom_data_i), .rd_idx(head_addr[IDX_W:1]),
        .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    assign rom_req_o  = fetch;
    assign rom_addr_o = load_addr;
    assign rd_data_o  = {rd_hi, rd_lo};
endmodule

// File: tb/pfq_top_bench.sv
module pfq_top_bench;
    localparam int DEPTH = 8, ADDR_W = 25, WAIT_W = 4, CNT_W = 4;

    logic clk = 0, rst_n = 0;
    logic step_i = 0, sync_i = 0, flush_i = 0, pop_i = 0, pop_word_i = 0;
    logic [WAIT_W-1:0] seq_wait_i = 1;
    logic [ADDR_W-1:0] sync_addr_i = '0;
    logic rom_req_o;
    logic [ADDR_W-1:0] rom_addr_o;
    logic [15:0] rom_data_i;
    logic [31:0] rd_data_o;
    logic [CNT_W-1:0] level_o;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] rom_fn(input logic [ADDR_W-1:0] a);
        return a[16:1] ^ 16'h5A3C ^ {a[8:1], a[16:9]};
    endfunction
    assign rom_data_i = rom_fn(rom_addr_o);

    pfq_top #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_pfq_top (.*);

    // Behavioural model
    logic [15:0] hq[$];
    bit m_active = 0;
    int m_head = 0, m_load = 0, m_wait = 0;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(string tag, bit st, int sw, bit sy, int sa, bit fl, bit pp, bit pw);
        bit exp_fetch;
        int need, wl;
        @(negedge clk);
        step_i = st; seq_wait_i = WAIT_W'(sw); sync_i = sy;
        sync_addr_i = ADDR_W'(sa); flush_i = fl; pop_i = pp; pop_word_i = pw;
        #1;
        wl = (sw == 0) ? 1 : sw;
        exp_fetch = !fl && !sy && m_active && hq.size() < DEPTH && st && m_wait <= 1;
        chk(tag, "level", level_o, hq.size());
        chk(tag, "rom_req", rom_req_o, exp_fetch);
        if (exp_fetch) chk(tag, "rom_addr", rom_addr_o, m_load);
        if (hq.size() >= 1) chk(tag, "rd_lo", rd_data_o[15:0], hq[0]);
        if (hq.size() >= 2) chk(tag, "rd_hi", rd_data_o[31:16], hq[1]);
        // model update
        if (fl) begin
            hq.delete(); m_active = 0;
        end else if (sy) begin
            if (!(m_active && (sa & ~1) == m_head)) begin
                hq.delete(); m_active = 1;
                m_head = sa & ~1; m_load = sa & ~1; m_wait = wl;
            end
        end else begin
            bit pop_ok;
            need = pw ? 2 : 1;
            pop_ok = pp && hq.size() >= need;
            if (m_active && hq.size() < DEPTH && st) begin
                if (m_wait <= 1) begin
                    hq.push_back(rom_fn(ADDR_W'(m_load)));
                    m_load += 2; m_wait = wl;
                end else m_wait--;
            end
            if (pop_ok) begin
                for (int k = 0; k < need; k++) void'(hq.pop_front());
                m_head += 2 * need;
            end
        end
    endtask

    initial begin
        int lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        step_i = 1;
        #1;
        chk("R1", "reset level", level_o, 0);
        chk("R1", "reset rom_req", rom_req_o, 0);
        rst_n = 1;
        cyc("R1", 1, 1, 0, 0, 0, 0, 0);
        cyc("R1", 1, 1, 0, 0, 0, 0, 0);
        // R2 start, R4 countdown with wait 3 then 2
        cyc("R2", 0, 3, 1, 'h101, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc("R4", 1, 2, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc("R4", 0, 2, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) cyc("R5", 1, 1, 0, 0, 0, 0, 0);
        // R6 full: keep stepping
        for (int i = 0; i < 10; i++) cyc("R6", 1, 1, 0, 0, 0, 0, 0);
        chk("R6", "full level", level_o, DEPTH);
        cyc("R7", 0, 1, 0, 0, 0, 1, 0);
        cyc("R8", 0, 1, 0, 0, 0, 1, 1);
        cyc("R3", 1, 1, 1, m_head, 0, 0, 0);
        chk("R3", "kept level", level_o, 5);
        cyc("R11", 1, 1, 0, 0, 0, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R8", 0, 1, 0, 0, 0, 1, 1);
        cyc("R8", 0, 1, 0, 0, 0, 1, 1);
        cyc("R7", 0, 1, 0, 0, 0, 1, 0);
        cyc("R7", 0, 1, 0, 0, 0, 1, 0);
        // R2 retarget with zero wait
        for (int i = 0; i < 5; i++) cyc("R5", 1, 1, 0, 0, 0, 0, 0);
        cyc("R2", 1, 0, 1, 'h3FE, 0, 1, 0);
        for (int i = 0; i < 12; i++) cyc("R4", 1, 0, 0, 0, 0, 0, 0);
        // R9 flush then steps
        cyc("R9", 1, 1, 0, 0, 1, 1, 0);
        for (int i = 0; i < 4; i++) cyc("R9", 1, 1, 0, 0, 0, 1, 0);
        // R10 flush beats sync, sync ignores pop
        cyc("R10", 1, 1, 1, 'h40, 1, 0, 0);
        cyc("R10", 1, 1, 0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 1, 'h40, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc("R10", 1, 1, 0, 0, 0, 0, 0);
        cyc("R10", 1, 1, 1, m_head, 0, 1, 1);
        cyc("R10", 1, 1, 0, 0, 0, 0, 0);
        // Pseudo-random mix
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 3000; i++) begin
            int r;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
            r = lfsr;
            cyc("R11", r[0] | r[1], r[4:3], r[9:5] == 0,
                r[10] ? m_head : (r[24:13] & ~1), r[13:7] == 0, r[11], r[12]);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule